// File: doc/BRIEF.md
# Quad Product Add-Subtract-Sum Datapath

This block is a fixed-function arithmetic slice with four multipliers. Each lane multiplies an m-bit multiplicand by an n-bit multiplier. Two pair stages then combine the products: lanes 0 and 1 in one stage, lanes 2 and 3 in the other. Each pair stage adds or subtracts its second product under its own control bit. A final adder sums the two pair results. The product, pair and sum widths grow by one bit at each stage, so the final sum is m+n+2 bits wide.

Two control bits set how operands are read. One chooses two's complement or unsigned for all multiplicands, and the other does the same for all multipliers. These bits and the two add/subtract bits travel through the same register stages as the data. A result therefore always uses the controls that were applied with its operands.

The block has three register stages: input, pipeline (after the multipliers) and output. A static parameter bypasses each stage. Every stage picks one of four clock enables and one of four synchronous resets through parameters. The operand input registers can form a shift chain for cascading neighbouring slices.

Top module: `quad_mac_sum`

## Requirements
- R1: `result` is the low m+n+2 bits of (A0·B0 ± A1·B1) + (A2·B2 ± A3·B3), where lane k of `a_data` is bits [k*m +: m] and lane k of `b_data` is bits [k*n +: n].
- R2: `sub0`=1 subtracts the lane 1 product from the lane 0 product, and `sub0`=0 adds it. `sub1` does the same for lanes 3 and 2.
- R3: `a_signed`=1 reads every multiplicand as two's complement, and 0 reads it as unsigned. `b_signed` does the same for the multipliers.
- R4: With all stages enabled and every selected enable high, a vector's result appears IN_REG+PIPE_REG+OUT_REG rising edges after it is applied, using the controls applied together with it.
- R5: When a stage's selected clock-enable bit is low and its reset bit is low, that stage holds its contents through the edge.
- R6: A high selected reset bit clears its stage to zero at the edge, whatever the enable. A reset bit that no stage selects has no effect. By default the input stage uses bit 0, the pipeline stage bit 1 and the output stage bit 3. The clock enables default to bits 0, 1 and 2.
- R7: A stage parameter of 0 removes that register from the path and shortens the latency by one edge.
- R8: With A_CHAIN=1, the multiplicand registers form a shift chain. Lane 0 loads `a_casc_in` and lane k loads lane k-1. `a_data` is then ignored. B_CHAIN does the same for the multipliers.
- R9: `a_casc_out` and `b_casc_out` always show the lane 3 operand input register. That register is clocked by the input stage even when IN_REG=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| ce_bank | input | 4 | Clock-enable bank; each stage uses one bit |
| rst_bank | input | 4 | Synchronous reset bank; each stage uses one bit |
| a_data | input | 4*A_W | Multiplicands, lane k at [k*A_W +: A_W] |
| b_data | input | 4*B_W | Multipliers, lane k at [k*B_W +: B_W] |
| a_signed | input | 1 | Multiplicands are two's complement |
| b_signed | input | 1 | Multipliers are two's complement |
| sub0 | input | 1 | Subtract in the lane 0/1 pair |
| sub1 | input | 1 | Subtract in the lane 2/3 pair |
| a_casc_in | input | A_W | Multiplicand shift-chain input |
| b_casc_in | input | B_W | Multiplier shift-chain input |
| a_casc_out | output | A_W | Lane 3 multiplicand register |
| b_casc_out | output | B_W | Lane 3 multiplier register |
| result | output | A_W+B_W+2 | Final sum |

## Verification
A control bit that slips a stage against its data would show up as the wrong sign or the wrong add/subtract. This shows at `result` on the first vector whose controls differ from those of its neighbour, at the full pipeline latency. The stream therefore changes signedness and operations on every cycle. A stage that ignores its enable or reset changes `result` or the cascade outputs one edge after the event, and the bench samples exactly there. A chain that shifts wrongly corrupts `a_casc_out` four edges after a value enters.

// File: rtl/dsp4_pkg.sv
package dsp4_pkg;
    localparam int NUM_LANES = 4;
    localparam int NUM_SEL   = 4;

    typedef struct packed {
        logic a_signed;
        logic b_signed;
        logic sub0;
        logic sub1;
    } ctrl_t;
endpackage

// File: rtl/dsp4_sel.sv
module dsp4_sel
    import dsp4_pkg::*;
#(
    parameter int SEL = 0
) (
    input  logic [NUM_SEL-1:0] bank,
    output logic               hit
);
    localparam logic [NUM_SEL-1:0] MASK = NUM_SEL'(1) << SEL;

    assign hit = |(bank & MASK);
endmodule

// File: rtl/dsp4_mult.sv
module dsp4_mult #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    input  logic               a_signed,
    input  logic               b_signed,
    output logic [A_W+B_W-1:0] prod
);
    localparam int P_W = A_W + B_W;

    logic [P_W-1:0] a_ext;
    logic [P_W-1:0] b_ext;

    always_comb begin
        a_ext = {{B_W{a_signed & a[A_W-1]}}, a};
        b_ext = {{A_W{b_signed & b[B_W-1]}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/dsp4_addsub.sv
module dsp4_addsub #(
    parameter int P_W = 16
) (
    input  logic         [P_W-1:0] x,
    input  logic         [P_W-1:0] y,
    input  logic                   in_signed,
    input  logic                   sub,
    output logic         [P_W:0]   res,
    output logic                   res_signed
);
    logic [P_W:0] x_ext;
    logic [P_W:0] y_ext;

    always_comb begin
        x_ext      = {in_signed & x[P_W-1], x};
        y_ext      = {in_signed & y[P_W-1], y};
        res        = sub ? (x_ext - y_ext) : (x_ext + y_ext);
        res_signed = in_signed | sub;
    end
endmodule

// File: rtl/quad_mac_sum.sv
module quad_mac_sum
    import dsp4_pkg::*;
#(
    parameter int A_W          = 8,
    parameter int B_W          = 8,
    parameter bit IN_REG       = 1'b1,
    parameter bit PIPE_REG     = 1'b1,
    parameter bit OUT_REG      = 1'b1,
    parameter bit A_CHAIN      = 1'b0,
    parameter bit B_CHAIN      = 1'b0,
    parameter int IN_CE_SEL    = 0,
    parameter int IN_RST_SEL   = 0,
    parameter int PIPE_CE_SEL  = 1,
    parameter int PIPE_RST_SEL = 1,
    parameter int OUT_CE_SEL   = 2,
    parameter int OUT_RST_SEL  = 3
) (
    input  logic                              clk,
    input  logic [NUM_SEL-1:0]                ce_bank,
    input  logic [NUM_SEL-1:0]                rst_bank,
    input  logic [NUM_LANES-1:0][A_W-1:0]     a_data,
    input  logic [NUM_LANES-1:0][B_W-1:0]     b_data,
    input  logic                              a_signed,
    input  logic                              b_signed,
    input  logic                              sub0,
    input  logic                              sub1,
    input  logic [A_W-1:0]                    a_casc_in,
    input  logic [B_W-1:0]                    b_casc_in,
    output logic [A_W-1:0]                    a_casc_out,
    output logic [B_W-1:0]                    b_casc_out,
    output logic [A_W+B_W+1:0]                result
);
    localparam int P_W   = A_W + B_W;
    localparam int R_W   = P_W + 1;
    localparam int S_W   = P_W + 2;
    localparam int PAIRS = NUM_LANES / 2;

    typedef struct packed {
        logic [NUM_LANES-1:0][A_W-1:0] a;
        logic [NUM_LANES-1:0][B_W-1:0] b;
        ctrl_t                         ctl;
    } in_t;

    typedef struct packed {
        logic [NUM_LANES-1:0][P_W-1:0] p;
        logic                          p_signed;
        logic [PAIRS-1:0]              sub;
    } pipe_t;

    typedef struct packed {
        in_t            in_s;
        pipe_t          pipe_s;
        logic [S_W-1:0] sum;
    } state_t;

    state_t st_d;
    state_t st_q;
    in_t    in_next;
    in_t    in_view;
    pipe_t  pipe_next;
    pipe_t  pipe_view;
    logic [S_W-1:0] sum_next;

    logic ce_in, ce_pipe, ce_out;
    logic rst_in, rst_pipe, rst_out;

    logic [NUM_LANES-1:0][P_W-1:0] prod;
    logic [PAIRS-1:0][R_W-1:0]     part;
    logic [PAIRS-1:0]              part_signed;

    // enable and reset selection per stage
    dsp4_sel #(.SEL(IN_CE_SEL))    u_sel_ce_in    (.bank(ce_bank),  .hit(ce_in));
    dsp4_sel #(.SEL(IN_RST_SEL))   u_sel_rst_in   (.bank(rst_bank), .hit(rst_in));
    dsp4_sel #(.SEL(PIPE_CE_SEL))  u_sel_ce_pipe  (.bank(ce_bank),  .hit(ce_pipe));
    dsp4_sel #(.SEL(PIPE_RST_SEL)) u_sel_rst_pipe (.bank(rst_bank), .hit(rst_pipe));
    dsp4_sel #(.SEL(OUT_CE_SEL))   u_sel_ce_out   (.bank(ce_bank),  .hit(ce_out));
    dsp4_sel #(.SEL(OUT_RST_SEL))  u_sel_rst_out  (.bank(rst_bank), .hit(rst_out));

    // input stage: parallel load or shift chain
    always_comb begin
        in_next.a            = a_data;
        in_next.b            = b_data;
        in_next.ctl.a_signed = a_signed;
        in_next.ctl.b_signed = b_signed;
        in_next.ctl.sub0     = sub0;
        in_next.ctl.sub1     = sub1;
        if (A_CHAIN) begin
            in_next.a[0] = a_casc_in;
            for (int k = 1; k < NUM_LANES; k++) begin
                in_next.a[k] = st_q.in_s.a[k-1];
            end
        end
        if (B_CHAIN) begin
            in_next.b[0] = b_casc_in;
            for (int k = 1; k < NUM_LANES; k++) begin
                in_next.b[k] = st_q.in_s.b[k-1];
            end
        end
    end

    // a chained operand always comes from its register
    always_comb begin
        in_view = IN_REG ? st_q.in_s : in_next;
        if (A_CHAIN) begin
            in_view.a = st_q.in_s.a;
        end
        if (B_CHAIN) begin
            in_view.b = st_q.in_s.b;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dsp4_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
            .a        (in_view.a[g]),
            .b        (in_view.b[g]),
            .a_signed (in_view.ctl.a_signed),
            .b_signed (in_view.ctl.b_signed),
            .prod     (prod[g])
        );
    end

    always_comb begin
        pipe_next.p        = prod;
        pipe_next.p_signed = in_view.ctl.a_signed | in_view.ctl.b_signed;
        pipe_next.sub      = {in_view.ctl.sub1, in_view.ctl.sub0};
    end

    assign pipe_view = PIPE_REG ? st_q.pipe_s : pipe_next;

    for (genvar h = 0; h < PAIRS; h++) begin : g_pair
        dsp4_addsub #(.P_W(P_W)) u_addsub (
            .x          (pipe_view.p[2*h]),
            .y          (pipe_view.p[2*h+1]),
            .in_signed  (pipe_view.p_signed),
            .sub        (pipe_view.sub[h]),
            .res        (part[h]),
            .res_signed (part_signed[h])
        );
    end

    always_comb begin
        sum_next = {part_signed[0] & part[0][R_W-1], part[0]}
                 + {part_signed[1] & part[1][R_W-1], part[1]};
    end

    // next-state for every register stage
    always_comb begin
        st_d = st_q;
        if (rst_in) begin
            st_d.in_s = '0;
        end else if (ce_in) begin
            st_d.in_s = in_next;
        end
        if (rst_pipe) begin
            st_d.pipe_s = '0;
        end else if (ce_pipe) begin
            st_d.pipe_s = pipe_next;
        end
        if (rst_out) begin
            st_d.sum = '0;
        end else if (ce_out) begin
            st_d.sum = sum_next;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign result     = OUT_REG ? st_q.sum : sum_next;
    assign a_casc_out = st_q.in_s.a[NUM_LANES-1];
    assign b_casc_out = st_q.in_s.b[NUM_LANES-1];
endmodule

// File: rtl/dsp4_sva.sv
module dsp4_sva #(
    parameter int A_W         = 8,
    parameter int B_W         = 8,
    parameter bit OUT_REG     = 1'b1,
    parameter int IN_CE_SEL   = 0,
    parameter int IN_RST_SEL  = 0,
    parameter int OUT_CE_SEL  = 2,
    parameter int OUT_RST_SEL = 3
) (
    input logic                 clk,
    input logic [3:0]           ce_bank,
    input logic [3:0]           rst_bank,
    input logic [A_W-1:0]       a_casc_out,
    input logic [B_W-1:0]       b_casc_out,
    input logic [A_W+B_W+1:0]   result
);
    if (OUT_REG) begin : g_out_chk
        AST_OUT_CLEAR: assert property (@(posedge clk)
            rst_bank[OUT_RST_SEL] |=> (result == '0)); // R6

        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst_bank[OUT_RST_SEL])
            !ce_bank[OUT_CE_SEL] |=> $stable(result)); // R5
    end

    AST_CASC_CLEAR: assert property (@(posedge clk)
        rst_bank[IN_RST_SEL] |=> (a_casc_out == '0 && b_casc_out == '0)); // R9

    AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst_bank[IN_RST_SEL])
        !ce_bank[IN_CE_SEL] |=> ($stable(a_casc_out) && $stable(b_casc_out))); // R5
endmodule

bind quad_mac_sum dsp4_sva #(
    .A_W         (A_W),
    .B_W         (B_W),
    .OUT_REG     (OUT_REG),
    .IN_CE_SEL   (IN_CE_SEL),
    .IN_RST_SEL  (IN_RST_SEL),
    .OUT_CE_SEL  (OUT_CE_SEL),
    .OUT_RST_SEL (OUT_RST_SEL)
) u_sva (
    .clk        (clk),
    .ce_bank    (ce_bank),
    .rst_bank   (rst_bank),
    .a_casc_out (a_casc_out),
    .b_casc_out (b_casc_out),
    .result     (result)
);

// File: tb/tb_quad_mac_sum.sv
`timescale 1ns/1ps
module tb_quad_mac_sum;
    localparam int AW = 8;
    localparam int BW = 8;
    localparam int SW = AW + BW + 2;
    localparam int NDIR = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]          ce_bank, rst_bank;
    logic [3:0][AW-1:0]  a_data;
    logic [3:0][BW-1:0]  b_data;
    logic                a_signed, b_signed, sub0, sub1;
    logic [AW-1:0]       a_ci, aco, aco_c;
    logic [BW-1:0]       b_ci, bco, bco_c;
    logic [SW-1:0]       res, res_c;

    quad_mac_sum #(.A_W(AW), .B_W(BW)) dut (
        .clk(clk), .ce_bank(ce_bank), .rst_bank(rst_bank),
        .a_data(a_data), .b_data(b_data),
        .a_signed(a_signed), .b_signed(b_signed), .sub0(sub0), .sub1(sub1),
        .a_casc_in(a_ci), .b_casc_in(b_ci),
        .a_casc_out(aco), .b_casc_out(bco), .result(res)
    );

    quad_mac_sum #(.A_W(AW), .B_W(BW), .A_CHAIN(1'b1), .B_CHAIN(1'b1), .PIPE_REG(1'b0)) dut_c (
        .clk(clk), .ce_bank(ce_bank), .rst_bank(rst_bank),
        .a_data(a_data), .b_data(b_data),
        .a_signed(a_signed), .b_signed(b_signed), .sub0(sub0), .sub1(sub1),
        .a_casc_in(a_ci), .b_casc_in(b_ci),
        .a_casc_out(aco_c), .b_casc_out(bco_c), .result(res_c)
    );

    int n_run = 0;
    int n_fail = 0;
    int idx = 0;
    int vfrom = 0;

    logic [3:0][AW-1:0] h_a [0:1023];
    logic [3:0][BW-1:0] h_b [0:1023];
    logic [3:0]         h_ctl [0:1023]; // {a_signed, b_signed, sub0, sub1}

    function automatic longint val_a(logic [AW-1:0] v, logic s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic longint val_b(logic [BW-1:0] v, logic s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic logic [SW-1:0] model(logic [3:0][AW-1:0] a, logic [3:0][BW-1:0] b,
                                            logic [3:0] ctl);
        longint p [4];
        longint t;
        for (int k = 0; k < 4; k++) p[k] = val_a(a[k], ctl[3]) * val_b(b[k], ctl[2]);
        t = (ctl[1] ? p[0] - p[1] : p[0] + p[1]) + (ctl[0] ? p[2] - p[3] : p[2] + p[3]);
        return SW'(t);
    endfunction

    function automatic logic [SW-1:0] exp_of(int i);
        return model(h_a[i], h_b[i], h_ctl[i]);
    endfunction

    task automatic check(string tag, longint act, longint expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic drive_next();
        if (idx >= NDIR) begin
            for (int k = 0; k < 4; k++) begin
                h_a[idx][k] = AW'($urandom);
                h_b[idx][k] = BW'($urandom);
            end
            h_ctl[idx] = 4'($urandom);
        end
        a_data   = h_a[idx];
        b_data   = h_b[idx];
        {a_signed, b_signed, sub0, sub1} = h_ctl[idx];
        idx++;
    endtask

    task automatic sync_check(string tag);
        @(negedge clk);
        if (idx - 3 >= vfrom) check(tag, res, exp_of(idx - 3));
        if (idx - 1 >= vfrom) begin
            check("R9 a cascade out", aco, h_a[idx-1][3]);
            check("R9 b cascade out", bco, h_b[idx-1][3]);
        end
    endtask

    initial begin : main
        logic [SW-1:0] held;
        int last;
        logic [3:0][AW-1:0] ca, pa;
        logic [3:0][BW-1:0] cb, pb;
        void'($urandom(32'h1A2B3C4D));
        ce_bank = 4'hF; rst_bank = 4'hF;
        a_data = '0; b_data = '0; a_signed = 0; b_signed = 0; sub0 = 0; sub1 = 0;
        a_ci = '0; b_ci = '0;

        // directed corners
        for (int k = 0; k < 4; k++) begin
            h_a[0][k] = 8'hFF; h_b[0][k] = 8'hFF;
            h_a[1][k] = 8'h80; h_b[1][k] = 8'h80;
            h_a[2][k] = 8'h80; h_b[2][k] = 8'hFF;
            h_a[3][k] = AW'(k + 1); h_b[3][k] = 8'hFF;
        end
        h_ctl[0] = 4'b0000; // R1 unsigned max: 260100
        h_ctl[1] = 4'b1110; // R2 R3 signed, pair0 subtract: 32768
        h_ctl[2] = 4'b1001; // R3 signed A only, pair1 subtract
        h_ctl[3] = 4'b0111; // R3 signed B only, both subtract: 2

        repeat (2) @(negedge clk);
        check("R6 reset result", res, 0);
        check("R6 reset a cascade", aco, 0);
        check("R6 reset b cascade", bco, 0);
        check("R6 reset chained result", res_c, 0);
        rst_bank = 4'h0;

        // R1 R2 R3 R4 stream with changing controls
        for (int i = 0; i < 150; i++) begin
            sync_check("R1 R2 R3 R4 stream");
            drive_next();
        end

        // R5 output stage enable low
        sync_check("R4 stream");
        held = res;
        ce_bank = 4'b1011;
        drive_next();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R5 output hold", res, held);
            drive_next();
        end
        ce_bank = 4'hF;
        for (int i = 0; i < 10; i++) begin
            sync_check("R5 R4 after output hold");
            drive_next();
        end

        // R5 input stage enable low
        sync_check("R4 stream");
        ce_bank = 4'b1110;
        last = idx - 1;
        drive_next();
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            if (j >= 2) check("R5 input hold result", res, exp_of(last));
            check("R5 input hold cascade", aco, h_a[last][3]);
            drive_next();
        end
        ce_bank = 4'hF;
        vfrom = idx - 1;
        for (int i = 0; i < 10; i++) begin
            sync_check("R5 R4 after input hold");
            drive_next();
        end

        // R6 pipeline reset bit 1
        sync_check("R4 stream");
        rst_bank = 4'b0010;
        drive_next();
        sync_check("R4 stream");
        rst_bank = 4'b0000;
        drive_next();
        @(negedge clk);
        check("R6 pipeline reset zero", res, 0);
        drive_next();
        for (int i = 0; i < 6; i++) begin
            sync_check("R6 after pipeline reset");
            drive_next();
        end

        // R6 unselected reset bit 2 has no effect
        sync_check("R4 stream");
        rst_bank = 4'b0100;
        drive_next();
        for (int i = 0; i < 5; i++) begin
            sync_check("R6 unselected reset ignored");
            rst_bank = 4'b0000;
            drive_next();
        end

        // R6 output reset wins over enable low
        sync_check("R4 stream");
        ce_bank = 4'h0;
        rst_bank = 4'b1000;
        drive_next();
        @(negedge clk);
        check("R6 output reset with enable low", res, 0);
        rst_bank = 4'h0;
        ce_bank = 4'hF;
        vfrom = idx;
        for (int i = 0; i < 40; i++) begin
            sync_check("R1 R4 after output reset");
            drive_next();
        end

        // R7 R8 chained instance, pipeline bypassed
        @(negedge clk);
        rst_bank = 4'hF;
        @(negedge clk);
        rst_bank = 4'h0;
        {a_signed, b_signed, sub0, sub1} = 4'b1010;
        a_ci = '0; b_ci = '0;
        ca = '0; cb = '0; pa = '0; pb = '0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            check("R7 R8 chained result", res_c, model(pa, pb, 4'b1010));
            check("R8 a chain out", aco_c, ca[3]);
            check("R8 b chain out", bco_c, cb[3]);
            for (int k = 0; k < 4; k++) begin
                a_data[k] = AW'($urandom);
                b_data[k] = BW'($urandom);
            end
            a_ci = (t == 5) ? 8'h80 : AW'($urandom);
            b_ci = (t == 5) ? 8'hFF : BW'($urandom);
            pa = ca; pb = cb;
            for (int k = 3; k > 0; k--) begin
                ca[k] = ca[k-1];
                cb[k] = cb[k-1];
            end
            ca[0] = a_ci;
            cb[0] = b_ci;
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R4: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule